// File: doc/BRIEF.md
# Transceiver Mode and Fault Controller

This block decides whether a bus transceiver is actively on the bus or parked in its low-power state. A standby-request pin chooses the mode when nothing is wrong. Supply and temperature fault flags can override that choice. From that decision the block drives three things: an enable for the transmitter, an enable for the main receiver, and a select that routes the receive-data output either from the live bus comparator or from the wake-up detector. A mode indicator is also provided.

Leaving standby is not immediate. The block waits a programmable number of clock cycles, which stands in for the analog settling time. Any reason to stay in standby that appears during that wait cancels the transition.

The transmitter has three separate lockouts, and each one releases only after the transmit-data line has been seen high:
- a thermal lockout, which leaves the receiver and the mode untouched;
- a lockout set by a supply fault;
- a guard against the line being held dominant for too long.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the block is in standby: modeNormal=0, rxEn=0, txEn=0, rxSrcWake=1.
- R2: With no fault active, a standby pin held low moves the block to normal mode exactly MODE_DLY+1 clock edges after the pin is sampled low. In normal mode rxEn=1, rxSrcWake=0, and txEn=1 when no lockout is set.
- R3: The standby pin sampled high while in normal mode returns the block to standby at the next clock edge.
- R4: Each supply flag (main-supply standby undervoltage, I/O-supply undervoltage, switch-off undervoltage) forces standby whatever the pin says. The flag takes effect at the third clock edge after it is raised, because it passes two synchroniser stages first.
- R5: A supply fault that arrives during the wake delay aborts the transition. After the fault clears, the full delay starts again.
- R6: After any supply fault, txEn stays 0 in normal mode until the transmit line has been seen high. It returns one edge after that.
- R7: The over-temperature flag clears txEn at the third edge after it is raised, while modeNormal and rxEn stay 1. txEn returns only after the flag has cleared and the transmit line has been sampled high.
- R8: A transmit line held low (dominant) for DOM_LIMIT consecutive edges clears txEn at edge DOM_LIMIT. txEn returns one edge after the line is sampled high.
- R9: The standby pin going high during the wake delay aborts the transition. A later request waits the full delay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stbyReq | input | 1 | Standby request: 1 = standby, 0 = normal (pulled high when undriven) |
| txLevel | input | 1 | Transmit data level: 0 = dominant, 1 = recessive |
| vccStbyUv | input | 1 | Main-supply standby undervoltage flag (asynchronous) |
| vioUv | input | 1 | I/O-supply undervoltage flag (asynchronous) |
| offUv | input | 1 | Switch-off undervoltage flag (asynchronous) |
| overTemp | input | 1 | Over-temperature flag (asynchronous) |
| txEn | output | 1 | Transmitter driver enable |
| rxEn | output | 1 | Main receiver enable |
| modeNormal | output | 1 | 1 in normal mode, 0 in standby or during the wake delay |
| rxSrcWake | output | 1 | Receive mux select: 1 = wake-up detector, 0 = live bus |

## Verification
The interesting overlap is a fault, or a pin change, landing in the same cycle that the wake counter is advancing. In that cycle the abort and the count step compete for the next state.

The bench provokes this by raising the I/O-supply flag, and separately the standby pin, a few cycles into the wake delay. It then requires standby to hold well past the point where normal mode would have been entered, and requires a complete fresh delay after the cause clears.

A second overlap comes from holding the transmit line low while the over-temperature flag clears, or while a supply recovers. The bench judges this case by requiring txEn to stay low until the line goes high, even though the other enable terms have already returned.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
  typedef enum logic [1:0] {
    MD_STBY = 2'd0,
    MD_WAKE = 2'd1,
    MD_NORM = 2'd2
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic wakeClr;
    logic wakeInc;
  } strobeT;

  localparam int FLAG_CNT = 4;  // {overTemp, offUv, vioUv, vccStbyUv}
endpackage

// File: rtl/xmc_datapath.sv
module xmc_datapath
  import xmc_pkg::*;
#(
  parameter int MODE_DLY    = 8,
  parameter int DOM_LIMIT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [FLAG_CNT-1:0] rawFlags,
  input  logic                txLevel,
  input  strobeT              stb,
  output logic                supplyFault,
  output logic                hotFlag,
  output logic                wakeDone,
  output logic                domExpired
);
  localparam int WW = $clog2(MODE_DLY + 1);
  localparam int DW = $clog2(DOM_LIMIT + 1);
  localparam logic [WW-1:0] WAKE_LAST = WW'(MODE_DLY - 1);
  localparam logic [DW-1:0] DOM_LAST  = DW'(DOM_LIMIT - 1);

  logic [FLAG_CNT-1:0] syncQ [SYNC_STAGES];
  logic [WW-1:0] wakeCnt;
  logic [DW-1:0] domCnt;

  // fault flag synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= rawFlags;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign supplyFault = |syncQ[SYNC_STAGES-1][2:0];
  assign hotFlag     = syncQ[SYNC_STAGES-1][3];

  // wake delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wakeCnt <= '0;
    else if (stb.wakeClr)   wakeCnt <= '0;
    else if (stb.wakeInc)   wakeCnt <= wakeCnt + 1'b1;
  end
  assign wakeDone = (wakeCnt == WAKE_LAST);

  // dominant duration counter, saturating at its last value
  assign domExpired = !txLevel && (domCnt == DOM_LAST);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            domCnt <= '0;
    else if (txLevel)     domCnt <= '0;
    else if (!domExpired) domCnt <= domCnt + 1'b1;
  end
endmodule

// File: rtl/xmc_control.sv
module xmc_control
  import xmc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   stbyReq,
  input  logic   txLevel,
  input  logic   supplyFault,
  input  logic   hotFlag,
  input  logic   wakeDone,
  input  logic   domExpired,
  output strobeT stb,
  output logic   modeNormal,
  output logic   txEn,
  output logic   rxEn,
  output logic   rxSrcWake,
  output logic   thermLock,
  output logic   relWait,
  output logic   domLock
);
  modeT state, nextState;
  logic wantNormal;

  assign wantNormal = !stbyReq && !supplyFault;

  always_comb begin
    nextState = state;
    case (state)
      MD_STBY: if (wantNormal) nextState = MD_WAKE;
      MD_WAKE: begin
        if (!wantNormal)   nextState = MD_STBY;
        else if (wakeDone) nextState = MD_NORM;
      end
      MD_NORM: if (!wantNormal) nextState = MD_STBY;
      default: nextState = MD_STBY;
    endcase
  end

  always_comb begin
    stb.wakeClr = (state != MD_WAKE);
    stb.wakeInc = (state == MD_WAKE) && wantNormal && !wakeDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MD_STBY;
    else       state <= nextState;
  end

  // lockouts: each set by its cause, released by a recessive transmit line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thermLock <= 1'b0;
      relWait   <= 1'b0;
      domLock   <= 1'b0;
    end else begin
      if (hotFlag)          thermLock <= 1'b1;
      else if (txLevel)     thermLock <= 1'b0;
      if (supplyFault)      relWait   <= 1'b1;
      else if (txLevel)     relWait   <= 1'b0;
      if (domExpired)       domLock   <= 1'b1;
      else if (txLevel)     domLock   <= 1'b0;
    end
  end

  assign modeNormal = (state == MD_NORM);
  assign rxEn       = modeNormal;
  assign rxSrcWake  = !modeNormal;
  assign txEn       = modeNormal && !thermLock && !relWait && !domLock;
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xmc_pkg::*;
#(
  parameter int MODE_DLY    = 8,   // wake delay in cycles (about 11 us worth in silicon)
  parameter int DOM_LIMIT   = 32,  // dominant timeout in cycles
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic stbyReq,
  input  logic txLevel,
  input  logic vccStbyUv,
  input  logic vioUv,
  input  logic offUv,
  input  logic overTemp,
  output logic txEn,
  output logic rxEn,
  output logic modeNormal,
  output logic rxSrcWake
);
  strobeT stb;
  logic supplyFault, hotFlag, wakeDone, domExpired;
  logic thermLock, relWait, domLock;

  xmc_datapath #(
    .MODE_DLY(MODE_DLY), .DOM_LIMIT(DOM_LIMIT), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .rawFlags({overTemp, offUv, vioUv, vccStbyUv}),
    .txLevel(txLevel), .stb(stb),
    .supplyFault(supplyFault), .hotFlag(hotFlag),
    .wakeDone(wakeDone), .domExpired(domExpired)
  );

  xmc_control uCtl (
    .clk(clk), .rstN(rstN), .stbyReq(stbyReq), .txLevel(txLevel),
    .supplyFault(supplyFault), .hotFlag(hotFlag),
    .wakeDone(wakeDone), .domExpired(domExpired),
    .stb(stb), .modeNormal(modeNormal), .txEn(txEn), .rxEn(rxEn),
    .rxSrcWake(rxSrcWake), .thermLock(thermLock), .relWait(relWait),
    .domLock(domLock)
  );
endmodule

// File: rtl/xmc_checker.sv
module xmc_checker (
  input logic clk,
  input logic rstN,
  input logic stbyReq,
  input logic txLevel,
  input logic modeNormal,
  input logic rxEn,
  input logic txEn,
  input logic supplyFault,
  input logic thermLock,
  input logic relWait,
  input logic domLock
);
  p_wake_needs_pin_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeNormal) |-> $past(!stbyReq));

  p_pin_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeNormal && stbyReq) |=> !modeNormal);

  p_fault_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    supplyFault |=> (!modeNormal && relWait));

  p_release_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(relWait) |-> $past(txLevel));

  p_therm_rx_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (thermLock && modeNormal) |-> (rxEn && !txEn));

  p_dom_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(domLock) |-> $past(txLevel));
endmodule

bind xcvr_mode_ctrl xmc_checker uChk (
  .clk(clk), .rstN(rstN), .stbyReq(stbyReq), .txLevel(txLevel),
  .modeNormal(modeNormal), .rxEn(rxEn), .txEn(txEn),
  .supplyFault(supplyFault), .thermLock(thermLock),
  .relWait(relWait), .domLock(domLock)
);

// File: tb/xcvr_mode_ctrl_test.sv
module xcvr_mode_ctrl_test;
  localparam int MD = 8;
  localparam int DL = 32;

  logic clk = 1'b0;
  logic rstN, stbyReq, txLevel, vccStbyUv, vioUv, offUv, overTemp;
  logic txEn, rxEn, modeNormal, rxSrcWake;

  always #5 clk = ~clk;

  xcvr_mode_ctrl #(.MODE_DLY(MD), .DOM_LIMIT(DL)) uut (
    .clk(clk), .rstN(rstN), .stbyReq(stbyReq), .txLevel(txLevel),
    .vccStbyUv(vccStbyUv), .vioUv(vioUv), .offUv(offUv), .overTemp(overTemp),
    .txEn(txEn), .rxEn(rxEn), .modeNormal(modeNormal), .rxSrcWake(rxSrcWake)
  );

  // expected vector order: {modeNormal, rxEn, rxSrcWake, txEn}
  localparam logic [3:0] E_STBY = 4'b0010;
  localparam logic [3:0] E_NORM = 4'b1101;
  localparam logic [3:0] E_NOTX = 4'b1100;

  typedef struct {
    string      tag;
    logic [3:0] exp;
  } itemT;

  itemT q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic push(string tag, logic [3:0] exp);
    itemT it;
    it.tag = tag;
    it.exp = exp;
    q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic setFault(int which, logic v);
    case (which)
      0: vccStbyUv = v;
      1: vioUv     = v;
      default: offUv = v;
    endcase
  endtask

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin : mon
    itemT it;
    logic [3:0] got;
    while (q.size() > 0) begin
      it  = q.pop_front();
      got = {modeNormal, rxEn, rxSrcWake, txEn};
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s got %b exp %b", it.tag, got, it.exp);
      end
    end
  end

  initial begin : driver
    rstN = 1'b0; stbyReq = 1'b1; txLevel = 1'b1;
    vccStbyUv = 1'b0; vioUv = 1'b0; offUv = 1'b0; overTemp = 1'b0;
    tick(3);
    push("R1 reset state", E_STBY);
    @(negedge clk) rstN = 1'b1;
    tick(1);
    push("R1 after reset", E_STBY);

    // R2: wake delay
    @(negedge clk) stbyReq = 1'b0;
    tick(MD);
    push("R2 still waking", E_STBY);
    tick(1);
    push("R2 normal entered", E_NORM);

    // R3: back to standby at once
    @(negedge clk) stbyReq = 1'b1;
    tick(1);
    push("R3 pin exit", E_STBY);

    // R9: pin abort during wake delay
    @(negedge clk) stbyReq = 1'b0;
    tick(3);
    @(negedge clk) stbyReq = 1'b1;
    tick(1);
    push("R9 aborted", E_STBY);
    @(negedge clk) stbyReq = 1'b0;
    tick(MD);
    push("R9 full delay again", E_STBY);
    tick(1);
    push("R9 normal", E_NORM);

    // R8: dominant timeout
    @(negedge clk) txLevel = 1'b0;
    tick(DL - 1);
    push("R8 before limit", E_NORM);
    tick(1);
    push("R8 timed out", E_NOTX);
    @(negedge clk) txLevel = 1'b1;
    tick(1);
    push("R8 released", E_NORM);

    // R7: thermal lockout, receiver kept
    @(negedge clk) overTemp = 1'b1;
    tick(2);
    push("R7 before sync", E_NORM);
    tick(1);
    push("R7 tx off rx on", E_NOTX);
    @(negedge clk) begin overTemp = 1'b0; txLevel = 1'b0; end
    tick(3);
    push("R7 waits for tx high", E_NOTX);
    @(negedge clk) txLevel = 1'b1;
    tick(1);
    push("R7 tx restored", E_NORM);

    // R4: each supply flag forces standby
    for (int f = 0; f < 3; f++) begin
      @(negedge clk) setFault(f, 1'b1);
      tick(2);
      push("R4 before sync", E_NORM);
      tick(1);
      push("R4 forced standby", E_STBY);
      @(negedge clk) setFault(f, 1'b0);
      tick(2 + MD);
      push("R4 recovery delay", E_STBY);
      tick(1);
      push("R4 recovered", E_NORM);
    end

    // R5: fault during wake delay aborts
    @(negedge clk) stbyReq = 1'b1;
    tick(1);
    @(negedge clk) stbyReq = 1'b0;
    tick(3);
    @(negedge clk) vioUv = 1'b1;
    tick(3);
    push("R5 aborted", E_STBY);
    tick(6);
    push("R5 held past delay", E_STBY);
    @(negedge clk) vioUv = 1'b0;
    tick(2 + MD);
    push("R5 restart delay", E_STBY);
    tick(1);
    push("R5 normal", E_NORM);

    // R6: release-high needed after supply recovery
    @(negedge clk) vccStbyUv = 1'b1;
    tick(5);
    push("R6 in fault", E_STBY);
    @(negedge clk) begin vccStbyUv = 1'b0; txLevel = 1'b0; end
    tick(3 + MD);
    push("R6 normal tx blocked", E_NOTX);
    @(negedge clk) txLevel = 1'b1;
    tick(1);
    push("R6 tx allowed", E_NORM);

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got hang exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule